// File: doc/BRIEF.md
# Reference Clock Pre-Divider Chain

This block brings a reference input clock down to the rate that a downstream DPLL expects. The input clock arrives as a one-cycle enable strobe on a fast system clock. The block passes that strobe through three stages in a row, and each stage can be bypassed:

- an optional ÷4/÷5 prescaler, meant for inputs that run fast;
- a fractional stage that divides by P/Q, built as a phase accumulator;
- an integer divider whose programmed value is the wanted ratio minus one.

Each stage emits an enable strobe of its own. All of the chain is combinational from the input strobe to the output strobe, so an output strobe only ever sits in the same cycle as an input strobe.

Software loads the integer factor through a byte-wide write port in two steps. The first write goes to the low byte and is held in a staging register. The second write goes to the high byte, and only that write moves the full value into use. When the prescaler select is 00, the integer divider's two control bits are both 0 and the fractional settings are in their bypass form, a low-rate input such as a 1 PPS pulse passes straight to the output.

Top module: `prescale_chain`

## Requirements
- R1: A synchronous active-low reset clears the following to zero: the prescaler counter, the fractional accumulator, the integer counter, the staging byte and the active integer factor. After reset, with the integer divider enabled and nothing written, every input strobe gives an output strobe. out_en is low whenever in_en is low.
- R2: The prescaler select `hf_sel` works as follows. Code 2'b01 emits a strobe on every 4th input strobe and code 2'b10 on every 5th. Codes 2'b00 and 2'b11 pass each strobe through unchanged.
- R3: The fractional stage adds Q on each strobe it receives and emits a strobe when the sum reaches or exceeds P, then subtracts P. Starting from a cleared accumulator, after M received strobes it has emitted exactly floor(M·Q/P).
- R4: The fractional stage is bypassed, passing every strobe through, when Q = 0 or P < Q.
- R5: The integer divider is bypassed when both bits of `divn_ctl` are 0. For any other code it divides by the active factor plus one.
- R6: An output strobe lasts one system clock and appears in the same cycle as the input strobe that completes the count. With an active factor V and a cleared counter, it falls on input strobes V+1, 2(V+1), and so on.
- R7: On the write port, `wr_hi` = 0 selects the low 8 bits of the factor and `wr_hi` = 1 selects the upper 7 bits, taken from `wr_data[6:0]`. A low write only stages its byte and leaves the active factor unchanged. A high write makes {data[6:0], staged byte} active.
- R8: Any factor written above 19439 becomes active as 19439, so the largest division is 19440.
- R9: Every high write clears the integer counter to zero at that clock edge. An input strobe in the same cycle is judged against the old count and the old factor.
- R10: With `hf_sel` = 00, `divn_ctl` = 00 and Q = 0, out_en equals in_en in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | synchronous active-low reset |
| in_en | input | 1 | input clock strobe, one cycle per input edge |
| hf_sel | input | 2 | prescaler select: 00/11 pass, 01 ÷4, 10 ÷5 |
| frac_p | input | 16 | fractional numerator P |
| frac_q | input | 16 | fractional denominator Q |
| divn_ctl | input | 2 | integer divider control bits, 00 = bypass |
| wr_en | input | 1 | write strobe for the integer factor |
| wr_hi | input | 1 | 0 = low byte, 1 = high byte (commits) |
| wr_data | input | 8 | write data byte |
| out_en | output | 1 | divided output strobe |

## Verification
The two functions that can fall in the same cycle are the commit of the integer factor by a high write and an input strobe that reaches the integer counter. To provoke this, the bench first sets a factor of 2 and sends one strobe, which leaves the count at 1. It then issues a high write together with a strobe. No output is expected in that cycle, because the old count is not yet terminal. After it, exactly three more strobes are needed for the next output. A counter that failed to restart would fire on the very next strobe instead.

// File: rtl/prescale_pkg.sv
// Package: shared encodings for the reference pre-divider chain.
// Assumes: nothing; pure type and constant definitions.
package prescale_pkg;

    // Prescaler select encoding; both 00 and 11 pass the strobe through.
    typedef enum logic [1:0] {
        HF_PASS   = 2'b00,
        HF_DIV4   = 2'b01,
        HF_DIV5   = 2'b10,
        HF_PASS_B = 2'b11
    } hf_sel_t;

    localparam int HF_DIV4_LAST = 3;
    localparam int HF_DIV5_LAST = 4;

endpackage

// File: rtl/hf_stage.sv
// Module: hf_stage
// What: optional ÷4/÷5 prescaler acting on an enable strobe.
// Assumes: in_en is a one-cycle strobe; the output is combinational from
// in_en, so a strobe leaves in the same cycle it arrives.
module hf_stage
    import prescale_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       in_en,
    output logic       out_en
);

    generate
        if (PRESENT) begin : g_hf
            logic [2:0] cnt;
            logic [2:0] last;
            logic       active;

            // Decode the select into an active flag and a terminal count.
            always_comb begin
                active = 1'b0;
                last   = 3'(HF_DIV4_LAST);
                case (hf_sel_t'(sel))
                    HF_DIV4: begin active = 1'b1; last = 3'(HF_DIV4_LAST); end
                    HF_DIV5: begin active = 1'b1; last = 3'(HF_DIV5_LAST); end
                    default: begin active = 1'b0; last = 3'(HF_DIV4_LAST); end
                endcase
            end

            // Strobe out on the input strobe that meets the terminal count.
            always_comb begin
                if (active) out_en = in_en && (cnt >= last);
                else        out_en = in_en;
            end

            // Count input strobes; wrap at the terminal count; idle at zero.
            always_ff @(posedge clk) begin
                if (!rst_n)        cnt <= '0;
                else if (!active)  cnt <= '0;
                else if (in_en)    cnt <= (cnt >= last) ? 3'd0 : cnt + 3'd1;
            end
        end else begin : g_no_hf
            logic unused_ok;
            // No prescaler built: the strobe passes straight through.
            always_comb begin
                out_en    = in_en;
                unused_ok = ^{clk, rst_n, sel};
            end
        end
    endgenerate

endmodule

// File: rtl/frac_stage.sv
// Module: frac_stage
// What: P/Q fractional divider built as a phase accumulator. Adds Q per
// input strobe and emits a strobe when the sum reaches P, then subtracts P.
// Assumes: P and Q are held steady while in use; Q = 0 or P < Q selects
// pass-through and holds the accumulator at zero.
module frac_stage #(
    parameter int PQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PQ_W-1:0] p,
    input  logic [PQ_W-1:0] q,
    input  logic            in_en,
    output logic            out_en
);

    localparam int SUM_W = PQ_W + 1;

    logic [PQ_W-1:0]  acc;
    logic [SUM_W-1:0] sum;
    logic             hit;
    logic             enable;

    // Decide whether the settings describe a legal ratio and form the sum.
    always_comb begin
        enable = (q != '0) && (p >= q);
        sum    = {1'b0, acc} + {1'b0, q};
        hit    = (sum >= {1'b0, p});
    end

    // Emit on overflow of the accumulator, or pass through when bypassed.
    always_comb begin
        if (enable) out_en = in_en && hit;
        else        out_en = in_en;
    end

    // Advance the phase accumulator on each input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (!enable)  acc <= '0;
        else if (in_en)    acc <= hit ? PQ_W'(sum - {1'b0, p}) : PQ_W'(sum);
    end

endmodule

// File: rtl/divn_regs.sv
// Module: divn_regs
// What: two-step load of the integer factor. A low-byte write is staged; a
// high-byte write commits {high bits, staged byte}, clamped to MAX_VAL.
// Assumes: software writes low then high; commit is a same-cycle strobe.
module divn_regs #(
    parameter int DIVN_W  = 15,
    parameter int BYTE_W  = 8,
    parameter int MAX_VAL = 19439
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIVN_W-1:0] active,
    output logic              commit
);

    localparam int HI_W = DIVN_W - BYTE_W;

    logic [BYTE_W-1:0] stage_lo;
    logic [DIVN_W-1:0] cand;

    // Assemble the candidate value and flag the committing write.
    always_comb begin
        cand   = {wr_data[HI_W-1:0], stage_lo};
        commit = wr_en && wr_hi;
    end

    // Hold the low byte until the high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)               stage_lo <= '0;
        else if (wr_en && !wr_hi) stage_lo <= wr_data;
    end

    // Load the active factor on commit, limited to the legal top value.
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= '0;
        else if (commit) active <= (cand > DIVN_W'(MAX_VAL)) ? DIVN_W'(MAX_VAL) : cand;
    end

endmodule

// File: rtl/divn_stage.sv
// Module: divn_stage
// What: integer divider by (factor + 1) on an enable strobe, with bypass
// when both control bits are zero. Restarts from zero on every commit.
// Assumes: factor and restart come from divn_regs; output is same-cycle.
module divn_stage #(
    parameter int DIVN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl,
    input  logic [DIVN_W-1:0] factor,
    input  logic              restart,
    input  logic              in_en,
    output logic              out_en,
    output logic [DIVN_W-1:0] cnt
);

    logic enable;
    logic term;

    // Enable unless both control bits are low; detect terminal count.
    always_comb begin
        enable = (ctl != 2'b00);
        term   = (cnt >= factor);
    end

    // Strobe out on the terminal input strobe, or pass through in bypass.
    always_comb begin
        if (enable) out_en = in_en && term;
        else        out_en = in_en;
    end

    // Count strobes, reload at terminal count, clear on commit or bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= '0;
        else if (!enable)        cnt <= '0;
        else if (in_en)          cnt <= term ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/prescale_chain.sv
// Module: prescale_chain (top)
// What: prescaler -> fractional P/Q -> integer divider, all on strobes of
// one system clock, with a byte-wide port for loading the integer factor.
// Assumes: in_en is at most one cycle per input clock edge; configuration
// inputs are changed only while the chain is idle or in reset.
module prescale_chain #(
    parameter bit HF_PRESENT = 1'b1,
    parameter int PQ_W       = 16,
    parameter int DIVN_W     = 15,
    parameter int BYTE_W     = 8,
    parameter int DIVN_MAX   = 19439
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic [1:0]        hf_sel,
    input  logic [PQ_W-1:0]   frac_p,
    input  logic [PQ_W-1:0]   frac_q,
    input  logic [1:0]        divn_ctl,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              out_en
);

    logic              hf_out;
    logic              frac_out;
    logic [DIVN_W-1:0] divn_active;
    logic              divn_commit;
    logic [DIVN_W-1:0] divn_cnt;

    hf_stage #(.PRESENT(HF_PRESENT)) u_hf (
        .clk(clk), .rst_n(rst_n), .sel(hf_sel),
        .in_en(in_en), .out_en(hf_out)
    );

    frac_stage #(.PQ_W(PQ_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .p(frac_p), .q(frac_q),
        .in_en(hf_out), .out_en(frac_out)
    );

    divn_regs #(.DIVN_W(DIVN_W), .BYTE_W(BYTE_W), .MAX_VAL(DIVN_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .active(divn_active), .commit(divn_commit)
    );

    divn_stage #(.DIVN_W(DIVN_W)) u_divn (
        .clk(clk), .rst_n(rst_n), .ctl(divn_ctl), .factor(divn_active),
        .restart(divn_commit), .in_en(frac_out), .out_en(out_en),
        .cnt(divn_cnt)
    );

endmodule

// File: rtl/prescale_chain_chk.sv
// Module: prescale_chain_chk
// What: concurrent checks on the pre-divider chain, bound to the top.
// Assumes: signals are connected by name through the bind below.
module prescale_chain_chk #(
    parameter int PQ_W     = 16,
    parameter int DIVN_W   = 15,
    parameter int DIVN_MAX = 19439
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_en,
    input logic [1:0]        hf_sel,
    input logic [PQ_W-1:0]   frac_q,
    input logic [1:0]        divn_ctl,
    input logic              wr_en,
    input logic              wr_hi,
    input logic              out_en,
    input logic [DIVN_W-1:0] divn_active,
    input logic [DIVN_W-1:0] divn_cnt
);

    // R6: an output strobe only accompanies an input strobe.
    a_r6_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> in_en);

    // R10: full bypass copies the input strobe.
    a_r10_full_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (hf_sel == 2'b00 && divn_ctl == 2'b00 && frac_q == '0) |-> (out_en == in_en));

    // R7: a low-byte write leaves the active factor alone.
    a_r7_lo_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> $stable(divn_active));

    // R8: the active factor never exceeds the legal top value.
    a_r8_factor_limit: assert property (@(posedge clk) disable iff (!rst_n)
        divn_active <= DIVN_W'(DIVN_MAX));

    // R9: a committing write leaves the integer counter at zero.
    a_r9_commit_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (divn_cnt == '0));

endmodule

bind prescale_chain prescale_chain_chk #(
    .PQ_W(PQ_W), .DIVN_W(DIVN_W), .DIVN_MAX(DIVN_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .hf_sel(hf_sel),
    .frac_q(frac_q), .divn_ctl(divn_ctl), .wr_en(wr_en), .wr_hi(wr_hi),
    .out_en(out_en), .divn_active(divn_active), .divn_cnt(divn_cnt)
);

// File: tb/sim_prescale_chain.sv
module sim_prescale_chain;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_en = 1'b0;
    logic [1:0]  hf_sel = 2'b00;
    logic [15:0] frac_p = '0;
    logic [15:0] frac_q = '0;
    logic [1:0]  divn_ctl = 2'b00;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        out_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int seen   = 0;
    bit done   = 1'b0;

    prescale_chain u0 (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .hf_sel(hf_sel),
        .frac_p(frac_p), .frac_q(frac_q), .divn_ctl(divn_ctl),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .out_en(out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; in_en = 1'b0; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // One input strobe; out_en sampled mid-cycle, followed by gap idle cycles.
    task automatic pulse(input int gap);
        @(negedge clk); in_en = 1'b1; #1;
        if (out_en) seen++;
        @(negedge clk); in_en = 1'b0;
        for (int g = 1; g < gap; g++) @(negedge clk);
    endtask

    task automatic write_factor(input int v);
        @(negedge clk); wr_en = 1'b1; wr_hi = 1'b0; wr_data = v[7:0];
        @(negedge clk); wr_hi = 1'b1; wr_data = {1'b0, v[14:8]};
        @(negedge clk); wr_en = 1'b0; wr_hi = 1'b0;
    endtask

    function automatic int hf_ratio(input int s);
        return (s == 1) ? 4 : (s == 2) ? 5 : 1;
    endfunction

    initial begin
        int pl [5];
        int ql [5];
        int idx;
        pl = '{0, 3, 5, 2, 7};
        ql = '{0, 2, 3, 3, 7};

        // R1: reset state and default factor zero
        do_reset();
        #1; check("R1 out low at reset idle", int'(out_en), 0);
        divn_ctl = 2'b01;
        seen = 0;
        for (int i = 0; i < 5; i++) pulse(1);
        check("R1 default factor divides by one", seen, 5);

        // R2 R3 R4 R5 R6 R10: sweep configurations
        idx = 0;
        for (int h = 0; h < 4; h++)
            for (int c = 0; c < 4; c++)
                for (int f = 0; f < 5; f++)
                    for (int d = 0; d < 4; d++) begin
                        int m, x, expd;
                        hf_sel = h[1:0]; divn_ctl = c[1:0];
                        frac_p = pl[f][15:0]; frac_q = ql[f][15:0];
                        do_reset();
                        write_factor(d);
                        m = 40;
                        seen = 0;
                        for (int k = 0; k < m; k++) pulse(1 + (idx % 2));
                        x = m / hf_ratio(h);
                        if (ql[f] != 0 && pl[f] >= ql[f]) x = (x * ql[f]) / pl[f];
                        expd = (c == 0) ? x : x / (d + 1);
                        check("R2 R3 R4 R5 R6 R10 sweep count", seen, expd);
                        idx++;
                    end

        // R6: position of each strobe, factor 2, no other stage
        hf_sel = 2'b00; frac_q = '0; frac_p = '0; divn_ctl = 2'b11;
        do_reset();
        write_factor(2);
        for (int k = 1; k <= 9; k++) begin
            seen = 0;
            pulse(1);
            check("R6 strobe position", seen, (k % 3 == 0) ? 1 : 0);
        end

        // R7: low byte alone keeps active factor 1
        write_factor(1);
        @(negedge clk); wr_en = 1'b1; wr_hi = 1'b0; wr_data = 8'd3;
        @(negedge clk); wr_en = 1'b0;
        seen = 0;
        for (int k = 0; k < 6; k++) pulse(1);
        check("R7 low write ignored", seen, 3);
        @(negedge clk); wr_en = 1'b1; wr_hi = 1'b1; wr_data = 8'd0;
        @(negedge clk); wr_en = 1'b0; wr_hi = 1'b0;
        seen = 0;
        for (int k = 0; k < 8; k++) pulse(1);
        check("R7 high write commits staged byte", seen, 2);

        // R9: commit and input strobe in the same cycle
        write_factor(2);
        seen = 0;
        pulse(1);
        @(negedge clk); wr_en = 1'b1; wr_hi = 1'b1; wr_data = 8'd0; in_en = 1'b1; #1;
        check("R9 commit cycle uses old count", int'(out_en), 0);
        @(negedge clk); wr_en = 1'b0; wr_hi = 1'b0; in_en = 1'b0;
        seen = 0;
        pulse(1); pulse(1);
        check("R9 no strobe before restart count", seen, 0);
        pulse(1);
        check("R9 strobe on third after restart", seen, 1);

        // R8: oversize factor clamps to divide by 19440
        @(negedge clk); wr_en = 1'b1; wr_hi = 1'b0; wr_data = 8'hFF;
        @(negedge clk); wr_hi = 1'b1; wr_data = 8'h7F;
        @(negedge clk); wr_en = 1'b0; wr_hi = 1'b0;
        seen = 0;
        for (int k = 0; k < 19439; k++) begin
            @(negedge clk); in_en = 1'b1; #1;
            if (out_en) seen++;
        end
        check("R8 none before 19440", seen, 0);
        @(negedge clk); in_en = 1'b1; #1;
        if (out_en) seen++;
        @(negedge clk); in_en = 1'b0;
        check("R8 strobe at 19440", seen, 1);

        // R10: full bypass with idle gaps
        hf_sel = 2'b00; divn_ctl = 2'b00; frac_q = '0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); in_en = k[0]; #1;
            check("R10 out equals in", int'(out_en), k & 1);
        end
        @(negedge clk); in_en = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule